// File: doc/BRIEF.md
# Iterative AES-128 Block Encryption Engine

This block turns one 128-bit plaintext block into ciphertext under a 128-bit cipher key, following the AES-128 standard. The round keys are not expanded here. A separate key expansion unit holds them and reports when they are ready. The engine asks for each round key by putting its index on `rk_sel`, and the unit answers on `rk_data` in the same cycle.

Software writes the plaintext first and then pulses the start command for one cycle. It then polls a sticky done flag. The engine first XORs the plaintext with round key 0 as it loads it. It then runs ten rounds, each taking four cycles. In each cycle one 32-bit column goes through the S-box. In the fourth cycle of a round, the byte rotation, the column mixing (skipped in the last round) and the round-key XOR are applied to the whole block. From the accepted start to the done flag takes exactly 40 cycles.

Top module: `aes128_enc_engine`

## Requirements
- R1: `ct_data` equals the AES-128 encryption of the plaintext under the key whose expanded round keys are served on `rk_data`. Block byte 0 sits in bits [127:120], and each group of four consecutive bytes forms a column. The vector with key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: A start pulse that is accepted at clock edge E makes `enc_done` read 1 after edge E+40. It reads 0 after edges E through E+39.
- R3: A start pulse while `key_ready` is 0 is ignored. `enc_done`, `ct_data` and `rk_sel` keep their values.
- R4: A start pulse while an encryption is running is ignored. The running encryption finishes at its original time with its original result.
- R5: `enc_done` is cleared by an accepted start and stays at 1 after completion until the next accepted start.
- R6: `rk_sel` reads 0 while idle. During round r (1 to 10) it reads r, and each round lasts four cycles.
- R7: `ct_data` changes only at the completion edge and holds its value at all other times.
- R8: After reset, `enc_done` is 0, `ct_data` is all zeros and `rk_sel` is 0.
- R9: `pt_data` is sampled only at the accepting edge. Later changes to it do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_data | input | 128 | Plaintext block |
| enc_start | input | 1 | One-cycle start command |
| key_ready | input | 1 | High when the expansion unit holds valid round keys |
| rk_sel | output | 4 | Index of the round key requested |
| rk_data | input | 128 | Round key for index `rk_sel` |
| ct_data | output | 128 | Ciphertext, held between encryptions |
| enc_done | output | 1 | Sticky completion flag |

## Verification
The engine is run with both published standard vectors. It is also swept over zero, all-ones and walking-byte plaintexts and over a sequence of pseudo-random plaintexts, under two keys. The expected results come from a bench-side cipher built on a brute-force S-box. The standard vectors confirm the byte and column order. The walking and random patterns separate errors in the row rotation, the column mixing and the per-column S-box slotting, since each of these would scramble different bytes. Start pulses are also given without key readiness and in the middle of a run, with the plaintext changed afterwards. These show that neither kind of pulse disturbs the timing, the index sequence or the result.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;
  localparam int NR     = 10;
  localparam int NCOL   = 4;
  localparam int COL_W  = 32;
  localparam int BLK_W  = NCOL * COL_W;
  localparam int RIDX_W = $clog2(NR + 1);
  localparam int SLOT_W = $clog2(NCOL);

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // x^254 = inverse in GF(2^8); zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq, r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [COL_W-1:0] mix_col(input logic [COL_W-1:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  // byte i lives at bits [BLK_W-1-8i -: 8]; row r of column c is byte 4c+r
  function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < 4; r++)
        o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*((c+r)%NCOL)+r) -: 8];
    return o;
  endfunction
endpackage

// File: rtl/aes_sub_col.sv
module aes_sub_col
  import aes_enc_pkg::*;
(
  input  logic [COL_W-1:0] din,
  output logic [COL_W-1:0] dout
);
  for (genvar b = 0; b < COL_W/8; b++) begin : g_byte
    assign dout[8*b +: 8] = sbox(din[8*b +: 8]);
  end
endmodule

// File: rtl/aes_round_fn.sv
module aes_round_fn
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] subbed,
  input  logic [BLK_W-1:0] rkey,
  input  logic             last_rnd,
  output logic [BLK_W-1:0] nxt
);
  logic [BLK_W-1:0] shifted;
  logic [BLK_W-1:0] mixed;

  assign shifted = shift_rows(subbed);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign mixed[BLK_W-1-COL_W*c -: COL_W] = mix_col(shifted[BLK_W-1-COL_W*c -: COL_W]);
  end

  assign nxt = (last_rnd ? shifted : mixed) ^ rkey;
endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl
  import aes_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              key_ready,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output logic              load_evt,
  output logic              round_end,
  output logic              fin_evt,
  output logic              last_rnd,
  output logic [RIDX_W-1:0] rk_idx
);
  logic [RIDX_W-1:0] rnd;

  assign load_evt  = start && key_ready && !busy;
  assign round_end = busy && (slot == SLOT_W'(NCOL-1));
  assign last_rnd  = (rnd == RIDX_W'(NR));
  assign fin_evt   = round_end && last_rnd;
  assign rk_idx    = busy ? rnd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rnd  <= '0;
      slot <= '0;
    end else if (load_evt) begin
      busy <= 1'b1;
      rnd  <= RIDX_W'(1);
      slot <= '0;
    end else if (busy) begin
      slot <= slot + 1'b1;
      if (round_end) begin
        if (last_rnd) busy <= 1'b0;
        else          rnd  <= rnd + 1'b1;
      end
    end
  end

  a_r3_no_accept_without_key: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !key_ready && !busy) |=> !busy);
  a_r4_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !round_end) |=> (busy && slot == $past(slot) + 1'b1));
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (round_end && !fin_evt) |=> (rk_idx == $past(rk_idx) + 1'b1));
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !round_end) |=> $stable(rk_idx));
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    rk_idx <= RIDX_W'(NR));
endmodule

// File: rtl/aes128_enc_engine.sv
module aes128_enc_engine
  import aes_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [127:0]      pt_data,
  input  logic              enc_start,
  input  logic              key_ready,
  output logic [3:0]        rk_sel,
  input  logic [127:0]      rk_data,
  output logic [127:0]      ct_data,
  output logic              enc_done
);
  localparam int BUF_W = BLK_W - COL_W;

  logic              busy, load_evt, round_end, fin_evt, last_rnd;
  logic [SLOT_W-1:0] slot;
  logic [RIDX_W-1:0] rk_idx;
  logic [BLK_W-1:0]  state_q;
  logic [BUF_W-1:0]  subbuf_q;
  logic [COL_W-1:0]  cur_col, sub_col;
  logic [BLK_W-1:0]  subbed_blk, round_out;

  aes_enc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (enc_start),
    .key_ready (key_ready),
    .busy      (busy),
    .slot      (slot),
    .load_evt  (load_evt),
    .round_end (round_end),
    .fin_evt   (fin_evt),
    .last_rnd  (last_rnd),
    .rk_idx    (rk_idx)
  );

  assign rk_sel = rk_idx;

  // column picked by the current slot
  always_comb begin
    cur_col = '0;
    for (int c = 0; c < NCOL; c++)
      if (slot == SLOT_W'(c)) cur_col = state_q[BLK_W-1-COL_W*c -: COL_W];
  end

  aes_sub_col u_sub (
    .din  (cur_col),
    .dout (sub_col)
  );

  assign subbed_blk = {subbuf_q, sub_col};

  aes_round_fn u_round (
    .subbed   (subbed_blk),
    .rkey     (rk_data),
    .last_rnd (last_rnd),
    .nxt      (round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= '0;
      subbuf_q <= '0;
    end else if (load_evt) begin
      state_q <= pt_data ^ rk_data;
    end else if (busy) begin
      if (round_end) state_q <= round_out;
      else begin
        for (int c = 0; c < NCOL-1; c++)
          if (slot == SLOT_W'(c)) subbuf_q[BUF_W-1-COL_W*c -: COL_W] <= sub_col;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ct_data  <= '0;
      enc_done <= 1'b0;
    end else begin
      if (fin_evt)       ct_data  <= round_out;
      if (load_evt)      enc_done <= 1'b0;
      else if (fin_evt)  enc_done <= 1'b1;
    end
  end

  a_r7_ct_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_evt |=> $stable(ct_data));
  a_r2_done_from_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_done) |-> $past(fin_evt));
  a_r5_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !enc_done);
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_done && !load_evt) |=> enc_done);
  a_r2_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_evt) |=> !enc_done);
endmodule

// File: tb/aes128_enc_engine_test.sv
`timescale 1ns/1ps
module aes128_enc_engine_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] pt_data = '0;
  logic         enc_start = 1'b0;
  logic         key_ready = 1'b0;
  logic [3:0]   rk_sel;
  logic [127:0] rk_data;
  logic [127:0] ct_data;
  logic         enc_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0]   sb [256];
  logic [127:0] rks [11];

  always #2.5 clk = ~clk;

  aes128_enc_engine uut (
    .clk(clk), .rst_n(rst_n), .pt_data(pt_data), .enc_start(enc_start),
    .key_ready(key_ready), .rk_sel(rk_sel), .rk_data(rk_data),
    .ct_data(ct_data), .enc_done(enc_done)
  );

  // modelled expansion unit: combinational lookup by index
  always_comb rk_data = (rk_sel <= 4'd10) ? rks[rk_sel] : '0;

  function automatic logic [7:0] m(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] aa = a;
    logic [7:0] bb = b;
    while (bb != 0) begin
      if (bb[0]) p ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
      bb = bb >> 1;
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0;
      logic [7:0] o;
      for (int b = 1; b < 256; b++) if (a != 0 && m(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[a] = o;
    end
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = m(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rks[0][127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) t[4*c+w] = sb[s[4*((c+w)%4)+w]];
      if (r < 10)
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
          t[4*c]   = m(a0,2) ^ m(a1,3) ^ a2 ^ a3;
          t[4*c+1] = a0 ^ m(a1,2) ^ m(a2,3) ^ a3;
          t[4*c+2] = a0 ^ a1 ^ m(a2,2) ^ m(a3,3);
          t[4*c+3] = m(a0,3) ^ a1 ^ a2 ^ m(a3,2);
        end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ rks[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one full run; optional mid-run start pulse (R4) and plaintext change (R9)
  task automatic run_enc(input logic [127:0] pt, input logic [127:0] exp, input string tag, input bit poke);
    int idx_bad = 0;
    int done_bad = 0;
    pt_data = pt;
    enc_start = 1'b1;
    @(negedge clk);
    enc_start = 1'b0;
    chk(enc_done == 1'b0, "R5 done cleared on accept", 128'(enc_done), 128'(0));
    for (int k = 0; k < 40; k++) begin
      if (rk_sel != 4'(1 + k/4)) idx_bad++;
      if (k > 0 && enc_done) done_bad++;
      if (k == 3) pt_data = ~pt;               // R9
      if (poke && k == 10) enc_start = 1'b1;   // R4
      if (poke && k == 11) enc_start = 1'b0;
      @(negedge clk);
    end
    chk(idx_bad == 0, "R6 round index sequence", 128'(idx_bad), 128'(0));
    chk(done_bad == 0, "R2 done low during run", 128'(done_bad), 128'(0));
    chk(enc_done == 1'b1, "R2 done after 40 cycles", 128'(enc_done), 128'(1));
    chk(ct_data == exp, tag, ct_data, exp);
    chk(rk_sel == 4'd0, "R6 index zero when idle", 128'(rk_sel), 128'(0));
  endtask

  task automatic idle_check(input int n, input logic [127:0] ct_exp, input bit done_exp, input string req);
    int mism = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (enc_done != done_exp || ct_data != ct_exp || rk_sel != 0) mism++;
    end
    chk(mism == 0, req, 128'(mism), 128'(0));
  endtask

  initial begin
    build_sbox();
    expand(128'h000102030405060708090a0b0c0d0e0f);
    repeat (3) @(negedge clk);
    chk(enc_done == 0 && ct_data == 0 && rk_sel == 0, "R8 reset state",
        {ct_data[123:0], enc_done, rk_sel[2:0]}, 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // R3: start without key readiness
    enc_start = 1'b1; @(negedge clk); enc_start = 1'b0;
    idle_check(45, 128'(0), 1'b0, "R3 start ignored without key ready");
    key_ready = 1'b1;
    chk(ref_enc(128'h00112233445566778899aabbccddeeff) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        "R1 bench reference self-test", ref_enc(128'h00112233445566778899aabbccddeeff),
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_enc(128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
            "R1 standard vector A", 1'b0);
    idle_check(20, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1, "R5 R7 done and ct hold");
    key_ready = 1'b0;
    enc_start = 1'b1; @(negedge clk); enc_start = 1'b0;
    idle_check(45, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1, "R3 ignored start keeps done and ct");
    key_ready = 1'b1;
    run_enc(128'h0, ref_enc(128'h0), "R1 zero block R4 mid-run start", 1'b1);
    run_enc({128{1'b1}}, ref_enc({128{1'b1}}), "R1 ones block", 1'b0);
    for (int i = 0; i < 16; i++) begin
      logic [127:0] p = 128'hff << (8*i);
      run_enc(p, ref_enc(p), "R1 walking byte", i == 7);
    end
    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    run_enc(128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32,
            "R1 standard vector B", 1'b0);
    begin
      logic [31:0] lcg = 32'h1234_5678;
      for (int i = 0; i < 12; i++) begin
        logic [127:0] p;
        for (int j = 0; j < 4; j++) begin
          lcg = lcg * 32'd1664525 + 32'd1013904223;
          p[32*j +: 32] = lcg;
        end
        run_enc(p, ref_enc(p), "R1 pseudo-random block", i == 5);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule